// File: doc/BRIEF.md
# 8-bit Timer with Power-of-Two Prescaler

This block is an 8-bit up-counter that measures time either in ticks of an internal instruction-rate strobe or in rising edges seen on an external pin. A prescaler can sit between the chosen source and the counter. It divides the event rate by 2, 4, 8 and so on up to 256. Its ratio comes from a 3-bit field, and no code gives 1:1. Software can also hand the prescaler to another unit. In that case the counter advances on every source event, and the block only reports the hand-off on a level output.

When the counter steps from 0xFF to 0x00 it raises a sticky overflow flag for the interrupt controller. The flag does not depend on any interrupt enable. It stays high until a clear strobe arrives. A small write bus loads the counter or the control register, and both values are available as registered read ports. Loading the counter restarts the prescaler, so each interval begins from a known phase. For example, loading 0x06 at the 2:1 ratio gives an overflow after exactly 500 source ticks.

Top module: `tmr8_timer`

## Requirements
- R1: After synchronous reset the counter reads 0x00, the overflow flag is low, the control register reads 0x00 and `psc_away` is low.
- R2: A bus write with `bus_addr`=1 updates the control register. Bit 5 selects the source (0 internal tick, 1 external pin). Bit 3 assigns the prescaler (0 to the timer, 1 away). Bits 2:0 hold the ratio code. Bits 7, 6 and 4 always read 0.
- R3: With bit 3 clear and ratio code k, the counter advances once per 2^(k+1) source events, so code 000 is 2:1 and code 111 is 256:1.
- R4: With bit 3 set, the counter advances on every source event and `psc_away` is high.
- R5: With bit 5 set, `tick_in` has no effect. Each rising edge of `ext_pin` becomes one source event, which takes effect at the third rising clock edge after the pin is first sampled high. A steady level and falling edges produce no event.
- R6: A step of the counter from 0xFF to 0x00 sets `ovf_flag` on the same edge.
- R7: `ovf_flag` stays high until `ovf_clr` is sampled high. If a wrap and a clear arrive on the same edge, the flag is set.
- R8: A bus write with `bus_addr`=0 loads `bus_wdata` into the counter. Any increment due on that edge is dropped, and the prescaler restarts from zero.
- R9: After loading 0x06 at code 000 with a tick on every cycle, the flag rises after exactly 500 ticks. After loading 0x00 at code 111, it rises after 65,536 ticks.
- R10: `cnt_rdata` shows the counter value one edge after it changes, and the counter never moves by more than one step per cycle except on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Internal instruction-rate strobe, one cycle wide |
| ext_pin | input | 1 | Asynchronous external count input |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the counter, 1 the control register |
| bus_wdata | input | 8 | Write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_rdata | output | 8 | Current counter value |
| opt_rdata | output | 8 | Control register readback |
| ovf_flag | output | 1 | Sticky overflow flag |
| psc_away | output | 1 | High while the prescaler is assigned away from the timer |

## Verification
A prescaler that holds a wrong phase shows at `cnt_rdata` as an increment landing one or more source events early or late. In the worst case the error appears only after a full 256-event ratio period. A wrong synchronizer depth or edge detector shifts the external-pin increments by whole cycles, or turns held levels into extra counts, and this is visible within a few edges of a pin toggle. The bench runs a cycle-level reference model against every output on every cycle, under random bus traffic with loads biased near 0xFF so that wraps, clears and their collisions occur often. Long directed intervals time the exact overflow cycle for the 500-tick and 65,536-tick cases.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int OPT_W       = 8;
  localparam int OPT_SRC_BIT = 5;
  localparam int OPT_ASG_BIT = 3;
  localparam int RATIO_W     = 3;
  localparam logic [OPT_W-1:0] OPT_RESET = '0;

  typedef enum logic {
    ADDR_COUNT  = 1'b0,
    ADDR_OPTION = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic               src_ext;
    logic               psc_away;
    logic [RATIO_W-1:0] ratio;
  } opt_t;
endpackage

// File: rtl/tmr8_pin_sync.sv
module tmr8_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise_pulse = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_evt,
  input  logic             bypass,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             restart,
  output logic             inc_evt
);
  localparam int PW = 2 ** SEL_W;
  localparam int SHW = SEL_W + 1;

  logic [PW-1:0]  div_q;
  logic [PW-1:0]  limit;
  logic [SHW-1:0] shift_amt;
  logic           at_limit;

  always_comb begin
    shift_amt = {1'b0, ratio_sel} + SHW'(1);
    limit     = ~({PW{1'b1}} << shift_amt);
    at_limit  = (div_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || restart || bypass) begin
      div_q <= '0;
    end else if (src_evt) begin
      if (at_limit) div_q <= '0;
      else          div_q <= div_q + PW'(1);
    end
  end

  assign inc_evt = bypass ? src_evt : (src_evt && at_limit);
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_evt,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             ovf_clr,
  output logic             cnt_load,
  output opt_t             opt_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);
  logic opt_load;
  logic wrap;

  always_comb begin
    cnt_load = bus_we && (reg_addr_e'(bus_addr) == ADDR_COUNT);
    opt_load = bus_we && (reg_addr_e'(bus_addr) == ADDR_OPTION);
    wrap     = !cnt_load && inc_evt && (cnt_q == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (cnt_load) cnt_q <= bus_wdata;
    else if (inc_evt)  cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (wrap)    flag_q <= 1'b1;
    else if (ovf_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q <= '0;
    end else if (opt_load) begin
      opt_q.src_ext  <= bus_wdata[OPT_SRC_BIT];
      opt_q.psc_away <= bus_wdata[OPT_ASG_BIT];
      opt_q.ratio    <= bus_wdata[RATIO_W-1:0];
    end
  end
endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
  import tmr8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             ext_pin,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic [OPT_W-1:0] opt_rdata,
  output logic             ovf_flag,
  output logic             psc_away
);
  opt_t opt;
  logic pin_rise;
  logic src_evt;
  logic inc_evt;
  logic cnt_load;

  tmr8_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .pin_async  (ext_pin),
    .rise_pulse (pin_rise)
  );

  assign src_evt = opt.src_ext ? pin_rise : tick_in;

  tmr8_prescaler #(.SEL_W(RATIO_W)) u_psc (
    .clk       (clk),
    .rst       (rst),
    .src_evt   (src_evt),
    .bypass    (opt.psc_away),
    .ratio_sel (opt.ratio),
    .restart   (cnt_load),
    .inc_evt   (inc_evt)
  );

  tmr8_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .inc_evt   (inc_evt),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ovf_clr   (ovf_clr),
    .cnt_load  (cnt_load),
    .opt_q     (opt),
    .cnt_q     (cnt_rdata),
    .flag_q    (ovf_flag)
  );

  always_comb begin
    opt_rdata                   = '0;
    opt_rdata[OPT_SRC_BIT]      = opt.src_ext;
    opt_rdata[OPT_ASG_BIT]      = opt.psc_away;
    opt_rdata[RATIO_W-1:0]      = opt.ratio;
  end

  assign psc_away = opt.psc_away;
endmodule

// File: rtl/tmr8_timer_chk.sv
module tmr8_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic             bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic [7:0]       opt_rdata,
  input logic             ovf_flag,
  input logic             psc_away
);
  logic cnt_wr;
  assign cnt_wr = bus_we && !bus_addr;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_rdata == '0 && !ovf_flag && opt_rdata == 8'h00 && !psc_away));

  // R2
  reserved_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (opt_rdata & 8'hD0) == 8'h00);

  // R6
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_rdata == '0 && $past(cnt_rdata) == {CNT_W{1'b1}} && !$past(cnt_wr) && !$past(rst))
      |-> ovf_flag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_rdata == $past(bus_wdata)));

  // R10
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> (cnt_rdata == $past(cnt_rdata) ||
                 cnt_rdata == CNT_W'($past(cnt_rdata) + CNT_W'(1))));
endmodule

bind tmr8_timer tmr8_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ovf_clr   (ovf_clr),
  .cnt_rdata (cnt_rdata),
  .opt_rdata (opt_rdata),
  .ovf_flag  (ovf_flag),
  .psc_away  (psc_away)
);

// File: tb/tmr8_timer_bench.sv
module tmr8_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0, ext_pin = 1'b0;
  logic       bus_we = 1'b0, bus_addr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] cnt_rdata, opt_rdata;
  logic       ovf_flag, psc_away;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  tmr8_timer u_tmr8_timer (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ext_pin(ext_pin),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ovf_clr(ovf_clr), .cnt_rdata(cnt_rdata), .opt_rdata(opt_rdata),
    .ovf_flag(ovf_flag), .psc_away(psc_away)
  );

  // ratio and interval functions derived from R3 and R9
  function automatic int ratio_of(input int code);
    return 1 << (code + 1);
  endfunction
  function automatic int ticks_to_ovf(input int load, input int code);
    return (256 - load) * ratio_of(code);
  endfunction
  function automatic logic [7:0] opt_view(input logic [7:0] w);
    return w & 8'h2F;
  endfunction

  // reference model of R1-R8 behaviour
  logic [7:0] m_cnt, m_opt, m_psc;
  logic       m_flag, m_s1, m_s2, m_s3;
  always @(posedge clk) begin
    logic evt, inc, wrap, ld;
    if (rst) begin
      m_cnt <= 0; m_opt <= 0; m_psc <= 0; m_flag <= 0;
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
    end else begin
      m_s1 <= ext_pin; m_s2 <= m_s1; m_s3 <= m_s2;
      evt  = m_opt[5] ? (m_s2 && !m_s3) : tick_in;
      ld   = bus_we && !bus_addr;
      inc  = 1'b0;
      if (m_opt[3]) begin
        inc = evt; m_psc <= 0;
      end else if (evt) begin
        if (int'(m_psc) == ratio_of(int'(m_opt[2:0])) - 1) begin
          inc = 1'b1; m_psc <= 0;
        end else m_psc <= m_psc + 1;
      end
      if (ld) m_psc <= 0;
      wrap = 1'b0;
      if (ld) m_cnt <= bus_wdata;
      else if (inc) begin m_cnt <= m_cnt + 1; wrap = (m_cnt == 8'hFF); end
      if (wrap) m_flag <= 1'b1;
      else if (ovf_clr) m_flag <= 1'b0;
      if (bus_we && bus_addr) m_opt <= opt_view(bus_wdata);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en && !rst) begin
    chk("R10 cnt_rdata vs model", cnt_rdata, m_cnt);
    chk("R7 ovf_flag vs model", ovf_flag, m_flag);
    chk("R2 opt_rdata vs model", opt_rdata, m_opt);
    chk("R4 psc_away vs model", psc_away, m_opt[3]);
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic pulse_clr();
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
  endtask

  // run ticks every cycle until flag rises; return tick count
  task automatic time_ovf(input int limit, output int n);
    n = 0;
    tick_in = 1;
    while (!ovf_flag && n < limit) begin
      @(negedge clk); n++;
    end
    tick_in = 0;
  endtask

  initial begin
    int n;
    void'($urandom(32'd2718));
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 reset count", cnt_rdata, 0);
    chk("R1 reset flag", ovf_flag, 0);
    chk("R1 reset option", opt_rdata, 0);
    cmp_en = 1;

    // R2 readback masks reserved bits
    wr(1, 8'hFF); chk("R2 option readback", opt_rdata, 8'h2F);
    wr(1, 8'h00); chk("R2 option cleared", opt_rdata, 8'h00);

    // R9 500-tick interval at 2:1
    wr(0, 8'h06);
    time_ovf(2000, n);
    chk("R9 ticks from 0x06 at 2:1", n, ticks_to_ovf(6, 0));
    chk("R6 counter wrapped", cnt_rdata, 0);
    idle(3); chk("R7 flag sticky", ovf_flag, 1);
    pulse_clr(); chk("R7 flag cleared", ovf_flag, 0);

    // R3 ratio 8:1 ; R8 load restarts prescaler
    wr(1, 8'h02); wr(0, 8'h10);
    tick_in = 1; idle(7); tick_in = 0;
    chk("R3 no step before 8 ticks", cnt_rdata, 8'h10);
    wr(0, 8'h20);
    tick_in = 1; idle(7); tick_in = 0;
    chk("R8 prescaler restarted by load", cnt_rdata, 8'h20);
    tick_in = 1; idle(1); tick_in = 0;
    chk("R3 step at 8th tick", cnt_rdata, 8'h21);

    // R4 prescaler away
    wr(1, 8'h0F);
    chk("R4 psc_away high", psc_away, 1);
    tick_in = 1; idle(5); tick_in = 0;
    chk("R4 one step per tick", cnt_rdata, 8'h26);

    // R5 external source, latency three edges
    wr(1, 8'h28); wr(0, 8'h00);
    tick_in = 1; idle(4); tick_in = 0;
    chk("R5 tick ignored in pin mode", cnt_rdata, 0);
    ext_pin = 1; idle(2);
    chk("R5 no step after two edges", cnt_rdata, 0);
    idle(1);
    chk("R5 step at third edge", cnt_rdata, 1);
    idle(10);
    chk("R5 held level no extra step", cnt_rdata, 1);
    ext_pin = 0; idle(5);
    chk("R5 falling edge ignored", cnt_rdata, 1);

    // R7 wrap wins over clear on the same edge
    wr(1, 8'h08); wr(0, 8'hFF);
    tick_in = 1; ovf_clr = 1; @(negedge clk); tick_in = 0; ovf_clr = 0;
    chk("R7 set beats clear", ovf_flag, 1);
    pulse_clr();

    // R9 maximum interval
    wr(1, 8'h07); wr(0, 8'h00);
    time_ovf(70000, n);
    chk("R9 maximum interval ticks", n, ticks_to_ovf(0, 7));
    pulse_clr();

    // random traffic checked against the model
    for (int i = 0; i < 6000; i++) begin
      tick_in = ($urandom % 3) != 0;
      if ($urandom % 4 == 0) ext_pin = ~ext_pin;
      ovf_clr = ($urandom % 8) == 0;
      bus_we = ($urandom % 12) == 0;
      bus_addr = $urandom % 2;
      bus_wdata = bus_addr ? 8'($urandom) :
                  (($urandom % 2) ? (8'hF8 | 8'($urandom)) : 8'($urandom));
      @(negedge clk);
    end
    bus_we = 0; ovf_clr = 0; tick_in = 0;
    idle(2);
    finish_run();
  end
endmodule